// File: doc/BRIEF.md
# Bus Arbitration Sequencer

This block gains a shared parallel bus for one device by arbitration. It watches the sensed busy, select and bus-reset lines, and it decides that the bus is free only after busy and select have both stayed low for a full settle interval. It then waits a minimum delay, drives busy, and drives its own ID bit onto the data bus. After the arbitration wait it compares the IDs present on the bus and either keeps the bus, asserting select, or lets it go.

Every delay is set by a parameter in nanoseconds and turned into whole clock cycles from the clock period parameter. Minimum delays are rounded up and maximum delays are rounded down. Three events make the block drop every driven line on the next clock edge: a bus reset, another device raising select during arbitration, and a bus-free condition seen while the block drives the bus. This keeps the release well inside the clear budget, because the release follows the bus-free detection edge by zero cycles.

Top module: `arb_seq`

## Requirements
- R1: The bus counts as free once busy, select and bus reset have been sensed low on SETTLE consecutive clock edges, where SETTLE is the settle time divided by the clock period and rounded up. A single high cycle on any of these lines restarts the count.
- R2: When a request is pending, busy and the data enable rise exactly FREE cycles after the bus-free detection edge, where FREE is the bus-free delay rounded up. With the defaults and an 8 ns clock that is 50 + 100 = 150 edges after the lines go quiet.
- R3: Busy never rises more than SET cycles after detection, where SET is the set window rounded down. If the bus stops being free, or the request is withdrawn, before busy rises, the attempt is dropped. A new attempt then needs a fresh bus-free detection.
- R4: While the data enable is high, the data output is one-hot with bit N set, where N is the 3-bit ID captured when arbitration starts.
- R5: The result is decided on the edge ARB cycles after busy rose, where ARB is the arbitration delay rounded up. The block wins when no data bit above its own ID is set. On a win it pulses won for one cycle, raises select on that same edge, and keeps busy.
- R6: On a loss the block drops busy and the data enable on the decision edge, pulses lost for one cycle, and waits for a fresh bus-free detection before it tries again.
- R7: If select is sensed high while the block arbitrates without driving select, busy and the data enable fall on the next edge.
- R8: A high bus-reset input drops busy, select and the data enable on the next edge and returns the block to idle. It overrides every other condition.
- R9: If a bus-free detection occurs while the block drives the bus, all driven lines fall on that detection edge.
- R10: After a win the block holds busy, select and its ID until the request falls, and it releases on the next edge.
- R11: The active-low reset clears all outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arb_req_i | input | 1 | Request to gain the bus |
| my_id_i | input | 3 | Own ID, 0 to 7 |
| bsy_i | input | 1 | Sensed busy line |
| sel_i | input | 1 | Sensed select line |
| bus_rst_i | input | 1 | Sensed bus reset line |
| data_i | input | 8 | Sensed data bus |
| bsy_o | output | 1 | Drive busy |
| sel_o | output | 1 | Drive select |
| data_o | output | 8 | Own ID bit to drive |
| data_oe_o | output | 1 | Data bus drive enable |
| won_o | output | 1 | One-cycle pulse on a won arbitration |
| lost_o | output | 1 | One-cycle pulse on a lost arbitration |

## Verification
The hardest state to reach is a bus-free detection while the block is driving. On a real wired bus the block's own busy keeps the line high, so the condition can never occur. The bench models each sensed line as the OR of the other devices and the block's own drive, and it can cut the block's own contribution once the block has won. Then the quiet interval runs while the block still holds the bus. The missed start window is reached in a similar way: other devices raise busy part way through the bus-free delay, and a request is withdrawn and then re-raised on a bus that is already free.

// File: rtl/arb_seq_pkg.sv
package arb_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DLY,
    ST_ARB,
    ST_HOLD
  } arb_state_e;
endpackage

// File: rtl/arb_free_detect.sv
module arb_free_detect #(
  parameter int SETTLE_CYC = 40,
  localparam int CW = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bsy_i,
  input  logic sel_i,
  input  logic bus_rst_i,
  output logic free_o,
  output logic free_pulse_o
);
  logic [CW-1:0] cnt_q;
  logic          quiet;

  assign quiet = !bsy_i && !sel_i && !bus_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!quiet)                     cnt_q <= '0;
    else if (cnt_q != CW'(SETTLE_CYC))   cnt_q <= cnt_q + 1'b1;
  end

  assign free_o       = (cnt_q == CW'(SETTLE_CYC));
  // high in the cycle whose closing edge completes the settle interval
  assign free_pulse_o = quiet && (cnt_q == CW'(SETTLE_CYC - 1));
endmodule

// File: rtl/arb_timer.sv
module arb_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           val_o <= '0;
    else if (clr_i)        val_o <= '0;
    else if (val_o != '1)  val_o <= val_o + 1'b1;
  end
endmodule

// File: rtl/arb_prio.sv
module arb_prio #(
  parameter int ID_W = 3,
  localparam int DATA_W = 1 << ID_W
) (
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              win_o
);
  logic [DATA_W-1:0] above;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign above[i] = (ID_W'(i) > id_i);
  end

  assign win_o = ~|(data_i & above);
endmodule

// File: rtl/arb_seq.sv
module arb_seq
  import arb_seq_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int SETTLE_NS = 400,
  parameter int FREE_NS   = 800,
  parameter int SET_NS    = 1800,
  parameter int ARB_NS    = 2400,
  parameter int ID_W      = 3,
  localparam int DATA_W   = 1 << ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arb_req_i,
  input  logic [ID_W-1:0]   my_id_i,
  input  logic              bsy_i,
  input  logic              sel_i,
  input  logic              bus_rst_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bsy_o,
  output logic              sel_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              won_o,
  output logic              lost_o
);
  localparam int SETTLE_CYC = (SETTLE_NS + CLK_NS - 1) / CLK_NS;
  localparam int FREE_CYC   = (FREE_NS + CLK_NS - 1) / CLK_NS;
  localparam int SET_CYC    = SET_NS / CLK_NS;
  localparam int ARB_CYC    = (ARB_NS + CLK_NS - 1) / CLK_NS;
  localparam int MAX_CYC    = (SET_CYC > ARB_CYC) ? SET_CYC : ARB_CYC;
  localparam int TW         = $clog2(MAX_CYC + 1);
  localparam int SW         = $clog2(SET_CYC + 2);
  localparam int AW         = $clog2(ARB_CYC + 1);

  arb_state_e      state_q, state_d;
  logic [TW-1:0]   tmr;
  logic [ID_W-1:0] id_q;
  logic            free_lvl, free_pulse, win;
  logic            dec_win, dec_lose, won_q, lost_q;

  arb_free_detect #(.SETTLE_CYC(SETTLE_CYC)) u_free (
    .clk_i, .rst_ni, .bsy_i, .sel_i, .bus_rst_i,
    .free_o(free_lvl), .free_pulse_o(free_pulse)
  );

  arb_timer #(.W(TW)) u_tmr (
    .clk_i, .rst_ni, .clr_i(state_d != state_q), .val_o(tmr)
  );

  arb_prio #(.ID_W(ID_W)) u_prio (
    .id_i(id_q), .data_i(data_i), .win_o(win)
  );

  always_comb begin
    state_d  = state_q;
    dec_win  = 1'b0;
    dec_lose = 1'b0;
    unique case (state_q)
      ST_IDLE: if (arb_req_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!arb_req_i)      state_d = ST_IDLE;
        else if (free_pulse) state_d = ST_DLY;
      end
      ST_DLY: begin
        if (!arb_req_i)                    state_d = ST_IDLE;
        else if (!free_lvl)                state_d = ST_WAIT;
        else if (tmr == TW'(FREE_CYC - 1)) state_d = ST_ARB;
        else if (tmr >= TW'(SET_CYC - 1))  state_d = ST_WAIT;
      end
      ST_ARB: begin
        if (sel_i || free_pulse) state_d = ST_WAIT;
        else if (tmr == TW'(ARB_CYC - 1)) begin
          if (win) begin state_d = ST_HOLD; dec_win  = 1'b1; end
          else     begin state_d = ST_WAIT; dec_lose = 1'b1; end
        end
      end
      ST_HOLD: begin
        if (!arb_req_i)      state_d = ST_IDLE;
        else if (free_pulse) state_d = ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
    if (bus_rst_i) begin
      state_d  = ST_IDLE;
      dec_win  = 1'b0;
      dec_lose = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
      won_q   <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      won_q   <= dec_win;
      lost_q  <= dec_lose;
      if (state_q == ST_DLY && state_d == ST_ARB) id_q <= my_id_i;
    end
  end

  assign bsy_o     = (state_q == ST_ARB) || (state_q == ST_HOLD);
  assign data_oe_o = bsy_o;
  assign sel_o     = (state_q == ST_HOLD);
  assign data_o    = data_oe_o ? (DATA_W'(1) << id_q) : '0;
  assign won_o     = won_q;
  assign lost_o    = lost_q;

  // independent observers for timing windows
  logic [SW-1:0] since_free;
  logic [AW-1:0] bsy_age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_free <= '0;
      bsy_age    <= '0;
    end else begin
      if (free_pulse)                          since_free <= '0;
      else if (since_free != SW'(SET_CYC + 1)) since_free <= since_free + 1'b1;
      if (!bsy_o)                              bsy_age <= '0;
      else if (bsy_age != AW'(ARB_CYC))        bsy_age <= bsy_age + 1'b1;
    end
  end

  p_free_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bsy_o) |-> since_free >= SW'(FREE_CYC));
  p_set_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bsy_o) |-> since_free <= SW'(SET_CYC));
  p_one_hot_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> ($countones(data_o) == 1));
  p_arb_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (won_o || lost_o) |-> bsy_age >= AW'(ARB_CYC));
  p_won_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(won_o && lost_o));
  p_won_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    won_o |-> (sel_o && bsy_o));
  p_lost_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> (!bsy_o && !data_oe_o));
  p_sel_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsy_o && !sel_o && sel_i) |=> (!bsy_o && !data_oe_o));
  p_bus_rst_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (!bsy_o && !sel_o && !data_oe_o));
  p_free_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsy_o && free_pulse) |=> !bsy_o);
  p_hold_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && !arb_req_i) |=> (!bsy_o && !sel_o));
endmodule

// File: tb/tb_arb_seq.sv
module tb_arb_seq;
  localparam int CLK_NS = 8;
  localparam int SETTLE = (400 + CLK_NS - 1) / CLK_NS;   // 50
  localparam int FREE   = (800 + CLK_NS - 1) / CLK_NS;   // 100
  localparam int ARB    = (2400 + CLK_NS - 1) / CLK_NS;  // 300
  localparam int NV     = 6;
  // {id, other devices' data, expect win}
  localparam logic [11:0] VEC [NV] = '{
    {3'd7, 8'h00, 1'b1},
    {3'd3, 8'h80, 1'b0},
    {3'd3, 8'h07, 1'b1},
    {3'd5, 8'h40, 1'b0},
    {3'd0, 8'h00, 1'b1},
    {3'd6, 8'h3F, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic arb_req = 1'b0, others_bsy = 1'b1, others_sel = 1'b0, bus_rst = 1'b0;
  logic loop_en = 1'b1;
  logic [2:0] my_id = '0;
  logic [7:0] others_data = '0;
  logic bsy_i, sel_i;
  logic [7:0] data_i, data_o;
  logic bsy_o, sel_o, data_oe_o, won_o, lost_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign bsy_i  = others_bsy | (loop_en & bsy_o);
  assign sel_i  = others_sel | (loop_en & sel_o);
  assign data_i = others_data | ((loop_en && data_oe_o) ? data_o : 8'h00);

  arb_seq #(.CLK_NS(CLK_NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .arb_req_i(arb_req), .my_id_i(my_id),
    .bsy_i(bsy_i), .sel_i(sel_i), .bus_rst_i(bus_rst), .data_i(data_i),
    .bsy_o(bsy_o), .sel_o(sel_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .won_o(won_o), .lost_o(lost_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bsy(output int n);
    n = 0;
    while (!bsy_o && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic quiet_bus();
    others_bsy = 1'b0; others_sel = 1'b0; others_data = '0;
  endtask

  task automatic arbitrate(input logic [2:0] id, input logic [7:0] oth, input bit exp_win);
    int n;
    my_id = id; arb_req = 1'b1; others_bsy = 1'b1;
    @(negedge clk);
    quiet_bus();
    wait_bsy(n);
    chk(n == SETTLE + FREE, "R2 start delay", n, SETTLE + FREE);
    chk(data_oe_o && data_o == (8'h01 << id), "R4 id bit", int'(data_o), int'(8'h01 << id));
    others_data = oth; others_bsy = (oth != 8'h00);
    n = 0;
    while (!(won_o || lost_o) && n < 2000) begin @(negedge clk); n++; end
    chk(n == ARB, "R5 decision delay", n, ARB);
    if (exp_win) chk(won_o && !lost_o && sel_o && bsy_o, "R5 win", {won_o, sel_o, bsy_o}, 3'b111);
    else         chk(lost_o && !won_o && !bsy_o && !data_oe_o, "R6 loss", {lost_o, bsy_o, data_oe_o}, 3'b100);
    @(negedge clk);
    chk(!won_o && !lost_o, exp_win ? "R5 pulse" : "R6 pulse", {won_o, lost_o}, 0);
  endtask

  task automatic cleanup();
    bus_rst = 1'b1; arb_req = 1'b0; others_bsy = 1'b1; others_data = '0; others_sel = 1'b0;
    loop_en = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    chk(!bsy_o && !sel_o && !data_oe_o && !won_o && !lost_o, "R11 reset state",
        {bsy_o, sel_o, data_oe_o, won_o, lost_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2, R4, R5, R6, R10
    for (int v = 0; v < NV; v++) begin
      arbitrate(VEC[v][11:9], VEC[v][8:1], VEC[v][0]);
      if (VEC[v][0]) begin
        chk(bsy_o && sel_o && data_oe_o, "R10 hold", {bsy_o, sel_o, data_oe_o}, 3'b111);
        arb_req = 1'b0;
        @(negedge clk);
        chk(!bsy_o && !sel_o && !data_oe_o, "R10 release", {bsy_o, sel_o, data_oe_o}, 0);
      end
      cleanup();
    end

    // R1: a one-cycle select glitch restarts the settle count
    my_id = 3'd2; arb_req = 1'b1;
    @(negedge clk);
    quiet_bus();
    repeat (SETTLE - 5) @(negedge clk);
    others_sel = 1'b1;
    @(negedge clk);
    others_sel = 1'b0;
    wait_bsy(n);
    chk(n == SETTLE + FREE, "R1 settle restart", n, SETTLE + FREE);
    // R8: bus reset during arbitration
    bus_rst = 1'b1;
    @(negedge clk);
    chk(!bsy_o && !data_oe_o && !sel_o, "R8 reset release", {bsy_o, data_oe_o, sel_o}, 0);
    cleanup();

    // R3: bus taken during the bus-free delay, then R7 on the retry
    arb_req = 1'b1;
    @(negedge clk);
    quiet_bus();
    repeat (SETTLE + FREE / 2) @(negedge clk);
    others_bsy = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (bsy_o) seen = 1'b1; end
    chk(!seen, "R3 abandoned attempt", seen, 0);
    quiet_bus();
    wait_bsy(n);
    chk(n == SETTLE + FREE, "R3 fresh detection", n, SETTLE + FREE);
    repeat (20) @(negedge clk);
    others_sel = 1'b1;
    @(negedge clk);
    chk(!bsy_o && !data_oe_o, "R7 select release", {bsy_o, data_oe_o}, 0);
    cleanup();

    // R3: request withdrawn, then re-raised on a bus already free
    arb_req = 1'b1;
    @(negedge clk);
    quiet_bus();
    repeat (SETTLE + FREE / 2) @(negedge clk);
    arb_req = 1'b0;
    repeat (20) @(negedge clk);
    arb_req = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (bsy_o) seen = 1'b1; end
    chk(!seen, "R3 needs new bus free", seen, 0);
    cleanup();

    // R6: after a loss a fresh bus-free period is needed
    arbitrate(3'd2, 8'h10, 1'b0);
    others_bsy = 1'b1; others_data = '0;
    repeat (20) @(negedge clk);
    chk(!bsy_o, "R6 no retry while busy", bsy_o, 0);
    quiet_bus();
    wait_bsy(n);
    chk(n == SETTLE + FREE, "R6 retry timing", n, SETTLE + FREE);
    cleanup();

    // R9: bus free seen while holding the bus
    arbitrate(3'd4, 8'h00, 1'b1);
    loop_en = 1'b0; quiet_bus();
    n = 0;
    while (bsy_o && n < 2000) begin @(negedge clk); n++; end
    chk(n == SETTLE, "R9 free release", n, SETTLE);
    chk(!sel_o && !data_oe_o, "R9 all lines", {sel_o, data_oe_o}, 0);
    cleanup();

    // R8: bus reset while holding after a win
    arbitrate(3'd1, 8'h01, 1'b1);
    bus_rst = 1'b1;
    @(negedge clk);
    chk(!bsy_o && !sel_o && !data_oe_o, "R8 reset in hold", {bsy_o, sel_o, data_oe_o}, 0);
    cleanup();

    // R11: asynchronous reset mid-arbitration
    my_id = 3'd5; arb_req = 1'b1;
    @(negedge clk);
    quiet_bus();
    wait_bsy(n);
    repeat (10) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk(!bsy_o && !data_oe_o && !sel_o && data_o == 8'h00, "R11 async clear",
           {bsy_o, data_oe_o, sel_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cleanup();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule